// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests for a processor core and decides, only at instruction boundaries, whether the core must enter an interrupt handler. It accepts two kinds of request. The first is a single non-maskable request that is edge-detected and latched. The second is a set of maskable sources, each held as one bit in a pending mask. Each maskable source has its own set and clear strobes.

When the core signals that an instruction has completed, the controller looks at the pending state held in that cycle. A latched non-maskable request always wins. Otherwise a nonzero maskable mask starts entry, but only when the core's interrupt-disable flag is low. On a take, the controller raises a one-cycle take pulse, reports which kind was taken, and outputs a 16-bit handler vector address. That address depends on the kind of request and on whether the core runs in its legacy (emulation) mode or its native mode.

Stacking of core state and the fetch from the vector address belong to the core. The outputs are plain control and status pins with no handshake. The core must act on the take pulse in the cycle it is high.

Top module: `intr_ctl`

## Requirements
- R1: A take (`take_o` high for one cycle) happens only in the cycle after a cycle with `insn_done_i` high; with `insn_done_i` low, pending requests only wait.
- R2: A rising edge on `nmi_i` sets `nmi_pend_o` on the next clock; a level held high latches only once, so after being taken the request stays clear while `nmi_i` remains high.
- R3: When `nmi_pend_o` is high in a cycle with `insn_done_i` high, the next cycle shows `take_o`=1 and `take_nmi_o`=1 whatever IRQs are pending, and `nmi_pend_o` clears, unless a new rising edge of `nmi_i` arrives in that same cycle, in which case it stays set.
- R4: Bit k of `irq_pend_o` is set one clock after `irq_set_i[k]` and cleared one clock after `irq_clr_i[k]`; when both strobes hit the same bit in the same cycle, the bit ends set; other bits are unaffected.
- R5: Without a pending NMI, a completed instruction leads to an IRQ take (`take_nmi_o`=0) only if `irq_pend_o` is nonzero and `irq_dis_i` is low in that cycle; taking an IRQ leaves `irq_pend_o` unchanged.
- R6: The vector on a take is 0xFFFA for NMI and 0xFFFE for IRQ when `emu_i` is high in the deciding cycle, and 0xFFEA for NMI and 0xFFEE for IRQ when it is low.
- R7: During and right after reset, `take_o`, `take_nmi_o`, `nmi_pend_o` and `irq_pend_o` are 0 and `vector_o` is 0x0000.
- R8: `vector_o` and `take_nmi_o` keep the values of the last take until the next take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request level, edge-detected |
| irq_set_i | input | N_SRC | Per-source set strobes for maskable requests |
| irq_clr_i | input | N_SRC | Per-source clear strobes for maskable requests |
| irq_dis_i | input | 1 | Core interrupt-disable flag |
| emu_i | input | 1 | Core runs in legacy (emulation) mode |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| take_o | output | 1 | One-cycle pulse: start interrupt entry |
| take_nmi_o | output | 1 | Kind of the last take: 1 = non-maskable |
| vector_o | output | 16 | Handler vector address of the last take |
| nmi_pend_o | output | 1 | Non-maskable request latched and waiting |
| irq_pend_o | output | N_SRC | Pending maskable sources |

## Verification
The bench targets priority and retention. An NMI arriving while IRQs are pending must win, and a design that ignored it would emit 0xFFEE/0xFFFE instead. A rising NMI edge in the same cycle that a previous NMI is taken must not be lost; a design that cleared unconditionally would drop it and never take the second request. A held-high NMI level must not be taken again, since a level-sensitive latch would take it on every boundary. The bench also covers simultaneous set and clear on one source, which a clear-priority mask would drop, and masked IRQs held off by the disable flag without losing their pending bits. Vector selection is checked in both modes for both kinds.

// File: rtl/intr_ctl_pkg.sv
package intr_ctl_pkg;
  localparam int unsigned VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_NMI_EMU = 16'hFFFA;
  localparam logic [VEC_W-1:0] VEC_IRQ_EMU = 16'hFFFE;
  localparam logic [VEC_W-1:0] VEC_NMI_NAT = 16'hFFEA;
  localparam logic [VEC_W-1:0] VEC_IRQ_NAT = 16'hFFEE;

  typedef enum logic {
    KIND_IRQ = 1'b0,
    KIND_NMI = 1'b1
  } take_kind_e;
endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic taken_i,
  output logic pend_o
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      // a fresh edge outranks the clear caused by a take
      pend_o <= rise | (pend_o & ~taken_i);
    end
  end
endmodule

// File: rtl/intr_irq_mask.sv
module intr_irq_mask #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             any_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_o[k] <= 1'b0;
      else if (set_i[k])   pend_o[k] <= 1'b1;
      else if (clr_i[k])   pend_o[k] <= 1'b0;
    end
  end

  assign any_o = |pend_o;
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_ctl_pkg::*;
#(
  parameter logic [VEC_W-1:0] NMI_EMU = VEC_NMI_EMU,
  parameter logic [VEC_W-1:0] IRQ_EMU = VEC_IRQ_EMU,
  parameter logic [VEC_W-1:0] NMI_NAT = VEC_NMI_NAT,
  parameter logic [VEC_W-1:0] IRQ_NAT = VEC_IRQ_NAT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             nmi_pend_i,
  input  logic             irq_any_i,
  input  logic             irq_dis_i,
  input  logic             emu_i,
  output logic             nmi_taken_o,
  output logic             take_o,
  output logic             take_nmi_o,
  output logic [VEC_W-1:0] vector_o
);
  logic       irq_go;
  take_kind_e kind;

  assign nmi_taken_o = done_i & nmi_pend_i;
  assign irq_go      = done_i & ~nmi_pend_i & irq_any_i & ~irq_dis_i;
  assign kind        = nmi_pend_i ? KIND_NMI : KIND_IRQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      take_nmi_o <= 1'b0;
      vector_o   <= '0;
    end else begin
      take_o <= nmi_taken_o | irq_go;
      if (nmi_taken_o | irq_go) begin
        take_nmi_o <= (kind == KIND_NMI);
        if (kind == KIND_NMI) vector_o <= emu_i ? NMI_EMU : NMI_NAT;
        else                  vector_o <= emu_i ? IRQ_EMU : IRQ_NAT;
      end
    end
  end
endmodule

// File: rtl/intr_ctl.sv
module intr_ctl
  import intr_ctl_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic [N_SRC-1:0] irq_set_i,
  input  logic [N_SRC-1:0] irq_clr_i,
  input  logic             irq_dis_i,
  input  logic             emu_i,
  input  logic             insn_done_i,
  output logic             take_o,
  output logic             take_nmi_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             nmi_pend_o,
  output logic [N_SRC-1:0] irq_pend_o
);
  logic nmi_taken;
  logic irq_any;

  intr_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_i   (nmi_i),
    .taken_i (nmi_taken),
    .pend_o  (nmi_pend_o)
  );

  intr_irq_mask #(.N_SRC(N_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_set_i),
    .clr_i  (irq_clr_i),
    .pend_o (irq_pend_o),
    .any_o  (irq_any)
  );

  intr_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (insn_done_i),
    .nmi_pend_i  (nmi_pend_o),
    .irq_any_i   (irq_any),
    .irq_dis_i   (irq_dis_i),
    .emu_i       (emu_i),
    .nmi_taken_o (nmi_taken),
    .take_o      (take_o),
    .take_nmi_o  (take_nmi_o),
    .vector_o    (vector_o)
  );
endmodule

// File: rtl/intr_ctl_chk.sv
module intr_ctl_chk
  import intr_ctl_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_i,
  input logic [N_SRC-1:0] irq_set_i,
  input logic             irq_dis_i,
  input logic             emu_i,
  input logic             insn_done_i,
  input logic             take_o,
  input logic             take_nmi_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             nmi_pend_o,
  input logic [N_SRC-1:0] irq_pend_o
);
  // R1
  p_take_at_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(insn_done_i));

  // R2
  p_nmi_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && $past(!nmi_i) && !insn_done_i) |=> nmi_pend_o);

  // R3
  p_nmi_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done_i && nmi_pend_o) |=> (take_o && take_nmi_o));

  // R4
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set_i != '0) |=> ((irq_pend_o & $past(irq_set_i)) == $past(irq_set_i)));

  // R5
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !take_nmi_o) |-> ($past(!irq_dis_i) && $past(irq_pend_o) != '0));

  // R6
  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vector_o == (take_nmi_o ? ($past(emu_i) ? VEC_NMI_EMU : VEC_NMI_NAT)
                                        : ($past(emu_i) ? VEC_IRQ_EMU : VEC_IRQ_NAT))));

  // R8
  p_vector_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_done_i) |=> ($stable(vector_o) && $stable(take_nmi_o)));
endmodule

bind intr_ctl intr_ctl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_i       (nmi_i),
  .irq_set_i   (irq_set_i),
  .irq_dis_i   (irq_dis_i),
  .emu_i       (emu_i),
  .insn_done_i (insn_done_i),
  .take_o      (take_o),
  .take_nmi_o  (take_nmi_o),
  .vector_o    (vector_o),
  .nmi_pend_o  (nmi_pend_o),
  .irq_pend_o  (irq_pend_o)
);

// File: tb/test_intr_ctl.sv
module test_intr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         nmi = 1'b0;
  logic [N-1:0] iset = '0;
  logic [N-1:0] iclr = '0;
  logic         dis = 1'b0;
  logic         emu = 1'b0;
  logic         done = 1'b0;
  logic         take, take_nmi, npend;
  logic [15:0]  vec;
  logic [N-1:0] ipend;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic        take;
    logic        is_nmi;
    logic [15:0] vec;
    logic        npend;
    logic [N-1:0] irq;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];

  // bench reference state
  logic         m_prev = 1'b0;
  logic         m_npend = 1'b0;
  logic [N-1:0] m_irq = '0;
  logic         m_isnmi = 1'b0;
  logic [15:0]  m_vec = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_ctl #(.N_SRC(N)) i_intr_ctl (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_set_i(iset), .irq_clr_i(iclr),
    .irq_dis_i(dis), .emu_i(emu), .insn_done_i(done),
    .take_o(take), .take_nmi_o(take_nmi), .vector_o(vec),
    .nmi_pend_o(npend), .irq_pend_o(ipend)
  );

  task automatic step(input logic a_nmi, input logic a_done, input logic a_dis,
                      input logic a_emu, input logic [N-1:0] a_set,
                      input logic [N-1:0] a_clr, input string tag);
    exp_t e;
    logic rise;
    @(negedge clk);
    nmi = a_nmi; done = a_done; dis = a_dis; emu = a_emu; iset = a_set; iclr = a_clr;
    rise = a_nmi & ~m_prev;
    e.take = 1'b0;
    if (a_done && m_npend) begin
      e.take = 1'b1; m_isnmi = 1'b1;
      m_vec = a_emu ? 16'hFFFA : 16'hFFEA;
      m_npend = rise;
    end else begin
      if (a_done && (m_irq != '0) && !a_dis) begin
        e.take = 1'b1; m_isnmi = 1'b0;
        m_vec = a_emu ? 16'hFFFE : 16'hFFEE;
      end
      m_npend = m_npend | rise;
    end
    m_irq  = (m_irq & ~a_clr) | a_set;
    m_prev = a_nmi;
    e.is_nmi = m_isnmi; e.vec = m_vec; e.npend = m_npend; e.irq = m_irq;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      exp_t  e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if (take !== e.take || take_nmi !== e.is_nmi || vec !== e.vec ||
          npend !== e.npend || ipend !== e.irq) begin
        bad++;
        $display("FAIL %s: got take=%b nmi=%b vec=%h npend=%b irq=%b exp take=%b nmi=%b vec=%h npend=%b irq=%b",
                 t, take, take_nmi, vec, npend, ipend, e.take, e.is_nmi, e.vec, e.npend, e.irq);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    // R7 reset state
    if (take !== 1'b0 || take_nmi !== 1'b0 || vec !== 16'h0000 || npend !== 1'b0 || ipend !== '0) begin
      bad++;
      $display("FAIL R7: got take=%b nmi=%b vec=%h npend=%b irq=%b exp all zero",
               take, take_nmi, vec, npend, ipend);
    end
    rst_n = 1'b1;
    step(0, 1, 0, 1, 4'b0000, 4'b0000, "R7 idle after reset");
    step(0, 1, 0, 1, 4'b0000, 4'b0000, "R5 empty mask no take");
    // IRQ set, no boundary yet
    step(0, 0, 0, 1, 4'b0010, 4'b0000, "R4 set source 1");
    step(0, 0, 0, 1, 4'b0000, 4'b0000, "R1 pending waits without boundary");
    step(0, 1, 0, 1, 4'b0000, 4'b0000, "R6 emu IRQ vector FFFE");
    step(0, 1, 1, 1, 4'b0000, 4'b0000, "R5 disabled keeps IRQ off");
    step(0, 0, 0, 1, 4'b0000, 4'b0000, "R8 vector held");
    step(0, 1, 0, 0, 4'b0000, 4'b0000, "R6 native IRQ vector FFEE");
    step(0, 1, 0, 0, 4'b0000, 4'b0000, "R5 pending bits kept after take");
    // NMI over pending IRQ
    step(1, 0, 0, 0, 4'b0000, 4'b0000, "R2 NMI edge latched");
    step(1, 0, 0, 0, 4'b0000, 4'b0000, "R1 NMI waits for boundary");
    step(1, 1, 1, 0, 4'b0000, 4'b0000, "R3 NMI wins native FFEA");
    step(1, 1, 0, 0, 4'b0000, 4'b0000, "R2 held level no relatch");
    step(1, 1, 0, 0, 4'b0000, 4'b0000, "R2 held level IRQ again");
    step(0, 0, 0, 1, 4'b0000, 4'b0000, "R8 hold after IRQ");
    // NMI in emu mode, with a new edge during the take
    step(1, 0, 0, 1, 4'b0000, 4'b0010, "R4 clear source 1");
    step(0, 0, 0, 1, 4'b0000, 4'b0000, "R2 latched after pulse");
    step(1, 1, 0, 1, 4'b0000, 4'b0000, "R3 emu FFFA and new edge kept");
    step(0, 1, 0, 1, 4'b0000, 4'b0000, "R3 second NMI taken");
    step(0, 1, 0, 1, 4'b0000, 4'b0000, "R3 NMI cleared, mask empty");
    // set and clear collisions
    step(0, 0, 0, 1, 4'b1001, 4'b1000, "R4 set wins over clear");
    step(0, 0, 0, 1, 4'b0100, 4'b0001, "R4 independent bits");
    step(0, 0, 0, 1, 4'b0000, 4'b1100, "R4 clear two bits");
    step(0, 1, 0, 0, 4'b0000, 4'b0000, "R5 empty after clears");
    step(0, 0, 0, 0, 4'b0000, 4'b0000, "R8 final hold");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule